// File: doc/BRIEF.md
# Gated-Periphery Banked Word Memory

This block is a synchronous single-port memory of 32-bit words spread over sixteen banks. Each bank is a 256-row array whose rows are 256 bits wide, so a row carries eight words. A 15-bit word address splits into a bank field, a row field and a column field. Requests, address and write data are captured in an input register on the rising clock edge. The captured request is then carried out in the next cycle. A write stores the word into the selected bank, row and column. A read senses the full row of the selected bank, picks one word by column, routes it by bank and loads it into the output register.

Beside the data path, the block drives enable lines that mark which periphery is working in the cycle. These are one select per bank, one enable each for the row and column decoders, and one sense enable per bank. They can be used as power-gating indicators. They are active only in the cycle that executes an access, and only for the bank that access uses.

The sequencing is a three-state machine held in the access register. In the state names below, the first letter stands for Idle and the others for Read and Write. `ST_IDLE` means nothing executes. `ST_READ` executes a captured read. `ST_WRITE` executes a captured write. From any state, a sampled write request moves to `ST_WRITE` (the write-wins transition). A sampled read request without a write moves to `ST_READ` (the read transition). No request returns to `ST_IDLE` (the rest transition). Reset forces `ST_IDLE`.

Top module: `sram_banked_gated`

## Requirements
- R1: The word address is laid out with the bank in bits 14:11, the row in bits 10:3 and the column in bits 2:0. Column c selects row bits 32c+31 down to 32c.
- R2: A write request sampled at a rising edge stores its word at the next rising edge. A read request sampled in the cycle right after the write returns the new word.
- R3: For a read request sampled at rising edge k, `rdata` shows the addressed word after edge k+1.
- R4: In the cycle after a read or write request is sampled, `bank_en` has exactly one bit set, the bit indexed by the bank field.
- R5: `row_dec_en` and `col_dec_en` are high in the cycle after a read or write request is sampled, and low otherwise.
- R6: `sense_en` equals `bank_en` in a cycle that executes a read. It is all zero in a cycle that executes a write.
- R7: When no request was sampled, every enable is low. Address and data changes during that time leave the stored contents unchanged.
- R8: If read and write are requested together, the write is carried out, no sense enable rises and `rdata` is not updated.
- R9: `rdata` keeps its value across every cycle that does not execute a read.
- R10: After reset, all enables are low and `rdata` is zero.
- R11: Words at the same row and column in different banks are independent, and so are neighbouring columns of one row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_req | input | 1 | Read request |
| wr_req | input | 1 | Write request (wins over read) |
| addr | input | 15 | Word address {bank, row, column} |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Output register |
| bank_en | output | 16 | One-hot bank select |
| row_dec_en | output | 1 | Row decoder enable |
| col_dec_en | output | 1 | Column decoder enable |
| sense_en | output | 16 | Per-bank sense enable |

## Verification
Two cases are tested where work overlaps in time. The first is a read and a write requested in the same cycle. The bench raises both requests together on a word whose contents are known. It then checks three things: the sense enables stay low, `rdata` keeps its earlier value, and a later read returns the written data. The second case is a write followed by a read of the same word in the very next cycle. The write commits at the edge where the read is captured. The read must therefore return the new word and not the stale one.

// File: rtl/sram_pkg.sv
package sram_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } acc_state_e;
endpackage

// File: rtl/sram_bank_decode.sv
module sram_bank_decode #(
    parameter int BANK_BITS = 4,
    localparam int NUM_BANKS = 1 << BANK_BITS
) (
    input  logic                 en,
    input  logic [BANK_BITS-1:0] bank,
    output logic [NUM_BANKS-1:0] onehot
);
    for (genvar i = 0; i < NUM_BANKS; i++) begin : g_dec
        assign onehot[i] = en && (bank == BANK_BITS'(i));
    end
endmodule

// File: rtl/sram_bank.sv
module sram_bank #(
    parameter int ROW_BITS = 8,
    parameter int COL_BITS = 3,
    parameter int WORD_W   = 32,
    localparam int NUM_ROWS = 1 << ROW_BITS,
    localparam int ROW_W    = WORD_W << COL_BITS
) (
    input  logic                clk,
    input  logic                wr_en,
    input  logic                sense_en,
    input  logic [ROW_BITS-1:0] row,
    input  logic [COL_BITS-1:0] col,
    input  logic [WORD_W-1:0]   wdata,
    output logic [WORD_W-1:0]   rd_word
);
    logic [ROW_W-1:0] cells [NUM_ROWS];
    logic [ROW_W-1:0] row_line;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            cells[row][32'(col) * WORD_W +: WORD_W] <= wdata;
        end
    end

    // whole row is sensed, then the column picks one word
    always_comb begin
        row_line = sense_en ? cells[row] : '0;
        rd_word  = row_line[32'(col) * WORD_W +: WORD_W];
    end
endmodule

// File: rtl/sram_word_mux.sv
module sram_word_mux #(
    parameter int NUM_BANKS = 16,
    parameter int WORD_W    = 32
) (
    input  logic [NUM_BANKS-1:0][WORD_W-1:0] words,
    input  logic [NUM_BANKS-1:0]             sel,
    output logic [WORD_W-1:0]                word
);
    always_comb begin
        word = '0;
        for (int i = 0; i < NUM_BANKS; i++) begin
            word = word | (words[i] & {WORD_W{sel[i]}});
        end
    end
endmodule

// File: rtl/sram_banked_gated.sv
module sram_banked_gated
    import sram_pkg::*;
#(
    parameter int BANK_BITS = 4,
    parameter int ROW_BITS  = 8,
    parameter int COL_BITS  = 3,
    parameter int WORD_W    = 32,
    localparam int NUM_BANKS = 1 << BANK_BITS,
    localparam int ADDR_W    = BANK_BITS + ROW_BITS + COL_BITS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rd_req,
    input  logic                 wr_req,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [WORD_W-1:0]    wdata,
    output logic [WORD_W-1:0]    rdata,
    output logic [NUM_BANKS-1:0] bank_en,
    output logic                 row_dec_en,
    output logic                 col_dec_en,
    output logic [NUM_BANKS-1:0] sense_en
);
    acc_state_e st_q, st_d;
    logic [ADDR_W-1:0] addr_q;
    logic [WORD_W-1:0] wdata_q;
    logic [WORD_W-1:0] rdata_q;
    logic              access, do_read, do_write;
    logic [BANK_BITS-1:0] bank_f;
    logic [ROW_BITS-1:0]  row_f;
    logic [COL_BITS-1:0]  col_f;
    logic [NUM_BANKS-1:0][WORD_W-1:0] bank_words;
    logic [WORD_W-1:0] sel_word;

    // next-state choice: write wins over read
    always_comb begin
        if (wr_req)      st_d = ST_WRITE;
        else if (rd_req) st_d = ST_READ;
        else             st_d = ST_IDLE;
    end

    // state register together with the input register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            addr_q  <= '0;
            wdata_q <= '0;
        end else begin
            st_q <= st_d;
            if (rd_req || wr_req) begin
                addr_q  <= addr;
                wdata_q <= wdata;
            end
        end
    end

    // output decode per state
    always_comb begin
        access   = 1'b0;
        do_read  = 1'b0;
        do_write = 1'b0;
        unique case (st_q)
            ST_IDLE:  ;
            ST_READ:  begin access = 1'b1; do_read  = 1'b1; end
            ST_WRITE: begin access = 1'b1; do_write = 1'b1; end
            default:  ;
        endcase
    end

    assign bank_f     = addr_q[ADDR_W-1 -: BANK_BITS];
    assign row_f      = addr_q[COL_BITS +: ROW_BITS];
    assign col_f      = addr_q[COL_BITS-1:0];
    assign row_dec_en = access;
    assign col_dec_en = access;

    sram_bank_decode #(.BANK_BITS(BANK_BITS)) u_dec (
        .en     (access),
        .bank   (bank_f),
        .onehot (bank_en)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        assign sense_en[b] = do_read && bank_en[b];
        sram_bank #(
            .ROW_BITS (ROW_BITS),
            .COL_BITS (COL_BITS),
            .WORD_W   (WORD_W)
        ) u_bank (
            .clk      (clk),
            .wr_en    (do_write && bank_en[b]),
            .sense_en (sense_en[b]),
            .row      (row_f),
            .col      (col_f),
            .wdata    (wdata_q),
            .rd_word  (bank_words[b])
        );
    end

    sram_word_mux #(.NUM_BANKS(NUM_BANKS), .WORD_W(WORD_W)) u_mux (
        .words (bank_words),
        .sel   (bank_en),
        .word  (sel_word)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       rdata_q <= '0;
        else if (do_read) rdata_q <= sel_word;
    end
    assign rdata = rdata_q;

    assert_one_bank_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_IDLE) |-> ($countones(bank_en) == 1 &&
            bank_en == (NUM_BANKS'(1) << $past(addr[ADDR_W-1 -: BANK_BITS]))));
    assert_dec_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rd_req && !wr_req) |-> (!row_dec_en && !col_dec_en));
    assert_sense_bank_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sense_en != '0) |-> (sense_en == bank_en));
    assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rd_req && !wr_req) |-> (bank_en == '0 && sense_en == '0));
    assert_write_no_sense_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_req) |-> (sense_en == '0));
    assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sense_en == '0) |=> $stable(rdata));
endmodule

// File: tb/tb_sram_banked_gated.sv
module tb_sram_banked_gated;
    localparam int PERIOD = 10;
    localparam int NV = 13;
    // {op(1=write,2=read), addr, data or expected}
    localparam logic [48:0] VEC [NV] = '{
        {2'd1, 15'h0000, 32'hA0000001},
        {2'd1, 15'h7FFF, 32'hF00000FF},
        {2'd1, 15'h188D, 32'h31750005},
        {2'd1, 15'h208D, 32'h41750005},
        {2'd1, 15'h188C, 32'h31740004},
        {2'd2, 15'h0000, 32'hA0000001},
        {2'd2, 15'h7FFF, 32'hF00000FF},
        {2'd2, 15'h188D, 32'h31750005},
        {2'd2, 15'h208D, 32'h41750005},
        {2'd2, 15'h188C, 32'h31740004},
        {2'd1, 15'h188D, 32'hDEADBEEF},
        {2'd2, 15'h188D, 32'hDEADBEEF},
        {2'd2, 15'h188C, 32'h31740004}
    };

    logic clk = 0, rst_n = 0, rd_req = 0, wr_req = 0;
    logic [14:0] addr = '0;
    logic [31:0] wdata = '0, rdata;
    logic [15:0] bank_en, sense_en;
    logic row_dec_en, col_dec_en;
    int checks = 0, failures = 0;
    logic [31:0] last_rd = '0;

    sram_banked_gated dut (.clk(clk), .rst_n(rst_n), .rd_req(rd_req), .wr_req(wr_req),
        .addr(addr), .wdata(wdata), .rdata(rdata), .bank_en(bank_en),
        .row_dec_en(row_dec_en), .col_dec_en(col_dec_en), .sense_en(sense_en));

    always #(PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_enables(input bit rd, input logic [14:0] a);
        logic [15:0] be;
        be = 16'(1) << a[14:11];
        chk("R4 bank_en one-hot of bank field", 32'(bank_en), 32'(be));
        chk("R5 decoder enables during access", {30'd0, row_dec_en, col_dec_en}, 32'd3);
        chk("R6 sense_en for access", 32'(sense_en), rd ? 32'(be) : 32'd0);
    endtask

    task automatic chk_quiet(input string req);
        chk(req, {bank_en, sense_en}, 32'd0);
        chk(req, {30'd0, row_dec_en, col_dec_en}, 32'd0);
    endtask

    // one access followed by an idle cycle; rd/wr may both be set
    task automatic access(input bit rd, input bit wr, input logic [14:0] a,
                          input logic [31:0] d);
        @(negedge clk);
        rd_req = rd; wr_req = wr; addr = a; wdata = d;
        @(negedge clk);
        rd_req = 0; wr_req = 0;
        chk_enables(rd && !wr, a);
        @(negedge clk);
        chk_quiet("R5 R7 enables low after access");
    endtask

    initial begin
        #(PERIOD * 100000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(PERIOD * 3);
        @(negedge clk);
        // R10 reset state
        chk_quiet("R10 enables after reset");
        chk("R10 rdata after reset", rdata, 32'd0);
        rst_n = 1;

        // R1 R2 R3 R11 table walk
        for (int i = 0; i < NV; i++) begin
            logic [1:0] op; logic [14:0] a; logic [31:0] d;
            {op, a, d} = VEC[i];
            access(op == 2'd2, op == 2'd1, a, d);
            if (op == 2'd2) begin
                chk("R1 R3 R11 read data", rdata, d);
                last_rd = d;
            end else begin
                chk("R9 rdata held across write", rdata, last_rd);
            end
        end

        // R7 idle cycles with moving address and data
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            addr = 15'(i * 4099); wdata = 32'hBAD0_0000 | 32'(i);
            @(negedge clk);
            chk_quiet("R7 enables in idle");
            chk("R9 rdata held in idle", rdata, last_rd);
        end
        access(1, 0, 15'h0000, 32'h0);
        chk("R7 contents unchanged by idle", rdata, 32'hA0000001);
        last_rd = rdata;

        // R8 simultaneous read and write
        access(1, 1, 15'h0000, 32'h12345678);
        chk("R8 rdata not updated on collision", rdata, last_rd);
        access(1, 0, 15'h0000, 32'h0);
        chk("R8 write carried out on collision", rdata, 32'h12345678);
        last_rd = rdata;

        // R2 write then read of the same word in the next cycle
        @(negedge clk);
        wr_req = 1; addr = 15'h4001; wdata = 32'hCAFEF00D;
        @(negedge clk);
        wr_req = 0; rd_req = 1;
        chk_enables(0, 15'h4001);
        @(negedge clk);
        rd_req = 0;
        chk_enables(1, 15'h4001);
        chk("R9 rdata before back-to-back read lands", rdata, last_rd);
        @(negedge clk);
        chk("R2 back-to-back read sees new word", rdata, 32'hCAFEF00D);
        @(negedge clk);
        chk("R9 rdata held afterwards", rdata, 32'hCAFEF00D);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule